// File: doc/BRIEF.md
# DMA Descriptor Error Capture Unit

This block sits beside the descriptor-driven DMA engine of a memory-card host controller and records the first error that the engine runs into. It watches the engine's state code, the descriptor fetch strobe with the descriptor's valid flag and address, and the completion strobe of each descriptor with its length and chain-end flag. It also sees the block count, the block length and the block-count-enable setting that software programmed for the transfer.

Two kinds of error are detected. The first is a descriptor that is fetched without its valid flag set. The second is a chain whose summed descriptor lengths do not agree with the block settings. When the first error occurs, the block freezes three things: a status byte holding a length-mismatch flag and the engine state code, the address of the offending descriptor, and a level interrupt. They stay frozen until software pulses a clear strobe.

Top module: `dma_err_capture`

## Requirements
- R1: After a synchronous reset, `status` is 8'h00, `err_addr` is 32'h0000_0000 and `irq` is 0.
- R2: A fetch strobe with the valid flag at 0 while `eng_state` is 2'b01 (fetch descriptor) is an error. After the next clock edge, `status[1:0]` is 2'b01, `status[2]` is 0, and `err_addr` holds `desc_addr` from that cycle.
- R3: A fetch strobe with the valid flag at 0 in any other engine state (2'b00 stop, 2'b10 change address, 2'b11 transfer) has no effect. A fetch strobe with the valid flag at 1 has no effect either.
- R4: A completion strobe counts only while `eng_state` is 2'b11 (transfer). When a completion carries the chain-end flag, `blk_cnt_en` is 1, and the chain total differs from `blk_cnt * blk_len`, this is an error. After the next edge, `status[2]` is 1, `status[1:0]` is 2'b11, and `err_addr` is the address of that ending descriptor, not the address of the one after it.
- R5: A chain total that is not an exact multiple of `blk_len` is also a length mismatch, whatever the value of `blk_cnt_en`. A `blk_len` of 0 always counts as a mismatch. When `blk_cnt_en` is 0, the product is not compared.
- R6: A descriptor length of 0 stands for 65536 bytes. The running total goes back to zero after every chain-end completion, so each chain is checked on its own.
- R7: `status[7:3]` always reads 0, and `status[1:0]` never shows 2'b10.
- R8: After the first error, later errors leave `status`, `err_addr` and `irq` unchanged until a clear is applied.
- R9: A clear pulse sets `status`, `err_addr` and `irq` to zero at the next edge. If a clear and an error arrive in the same cycle, the clear wins.
- R10: `irq` is a level equal to (error captured AND `irq_en`). It is updated at the same edge as the status, and it follows a change of `irq_en` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_state | input | 2 | Engine state: 00 stop, 01 fetch, 10 change address, 11 transfer |
| desc_fetch | input | 1 | A descriptor has been fetched this cycle |
| desc_valid | input | 1 | Valid flag of the fetched descriptor |
| desc_addr | input | 32 | Address of the current descriptor |
| desc_done | input | 1 | The current descriptor's data has completed |
| desc_len | input | 16 | Byte length of the completed descriptor (0 means 65536) |
| desc_end | input | 1 | The completed descriptor ends the chain |
| blk_cnt | input | 16 | Programmed block count |
| blk_len | input | 12 | Programmed block length in bytes |
| blk_cnt_en | input | 1 | Block count enable |
| irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | Clear strobe from software |
| irq | output | 1 | Error interrupt level |
| status | output | 8 | {5'b0, length mismatch, state code[1:0]} |
| err_addr | output | 32 | Captured descriptor address |

## Verification
Each error is sampled at the clock edge where its strobe is high. Status, captured address and interrupt are all registered at that same edge, so all of them are due exactly one edge after the stimulus. A change of the interrupt enable alone shows on `irq` one edge later. The bench drives every input at a falling edge and drops the strobes at the next falling edge. It checks the outputs at that same falling edge, which is half a period after the edge that registered them. Cases that must cause no change are checked at the same point, so a late or early update would be seen as a mismatch.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'b00,
    ST_FETCH = 2'b01,
    ST_CHADR = 2'b10,
    ST_XFER  = 2'b11
  } eng_state_e;
endpackage

// File: rtl/dma_fetch_mon.sv
module dma_fetch_mon
  import dma_err_pkg::*;
(
  input  logic       fetch,
  input  logic       valid,
  input  logic [1:0] state,
  output logic       bad_desc
);
  always_comb begin
    bad_desc = fetch && !valid && (state == ST_FETCH);
  end
endmodule

// File: rtl/dma_len_check.sv
module dma_len_check
  import dma_err_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16,
  parameter int BLEN_W = 12,
  parameter int SUM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        state,
  input  logic              done,
  input  logic [LEN_W-1:0]  len,
  input  logic              last,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic [BLEN_W-1:0] blk_len,
  input  logic              cnt_en,
  output logic              mismatch
);
  localparam logic [SUM_W-1:0] FULL_LEN = SUM_W'(1) << LEN_W;

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] len_eff;
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] product;
  logic [SUM_W-1:0] blen_ext;
  logic             accept;
  logic             bad_cnt;
  logic             bad_mod;

  always_comb begin
    accept   = done && (state == ST_XFER);
    len_eff  = (len == '0) ? FULL_LEN : SUM_W'(len);
    total    = sum_q + len_eff;
    blen_ext = SUM_W'(blk_len);
    product  = SUM_W'(blk_cnt) * blen_ext;
    bad_cnt  = cnt_en && (total != product);
    bad_mod  = (blen_ext == '0) ? 1'b1 : ((total % blen_ext) != '0);
    mismatch = accept && last && (bad_cnt || bad_mod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else if (accept) begin
      sum_q <= last ? '0 : total;
    end
  end

  // R6: running total restarts after a chain end
  assert_sum_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && last) |=> (sum_q == '0));
  // R4: completions outside the transfer state do not move the total
  assert_sum_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!accept) |=> $stable(sum_q));
endmodule

// File: rtl/dma_err_regs.sv
module dma_err_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_bad_desc,
  input  logic              ev_len,
  input  logic [1:0]        state,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  input  logic              irq_en,
  output logic              irq,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] err_addr
);
  logic              locked_q;
  logic              len_err_q;
  logic [1:0]        code_q;
  logic [ADDR_W-1:0] addr_q;
  logic              irq_q;
  logic              take;
  logic              locked_d;

  always_comb begin
    take     = !locked_q && (ev_bad_desc || ev_len);
    locked_d = clr ? 1'b0 : (locked_q || take);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q  <= 1'b0;
      len_err_q <= 1'b0;
      code_q    <= 2'b00;
      addr_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      locked_q <= locked_d;
      irq_q    <= locked_d && irq_en;
      if (clr) begin
        len_err_q <= 1'b0;
        code_q    <= 2'b00;
        addr_q    <= '0;
      end else if (take) begin
        len_err_q <= ev_len;
        code_q    <= state;
        addr_q    <= addr;
      end
    end
  end

  assign status   = {5'b00000, len_err_q, code_q};
  assign err_addr = addr_q;
  assign irq      = irq_q;

  // R7: state code 2'b10 never appears
  assert_no_chadr_code_R7: assert property (@(posedge clk) disable iff (rst)
    status[1:0] != 2'b10);
  // R8: frozen while locked and no clear
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !clr) |=> ($stable(addr_q) && $stable(code_q) && $stable(len_err_q)));
  // R9: clear empties everything
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (status == 8'h00 && !irq && err_addr == '0));
  // R10: interrupt tracks enable one edge later
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !clr) |=> (irq == $past(irq_en)));
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16,
  parameter int BLEN_W = 12,
  parameter int SUM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        eng_state,
  input  logic              desc_fetch,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_done,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_end,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic [BLEN_W-1:0] blk_len,
  input  logic              blk_cnt_en,
  input  logic              irq_en,
  input  logic              err_clr,
  output logic              irq,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] err_addr
);
  logic bad_desc;
  logic len_bad;

  dma_fetch_mon u_fetch (
    .fetch    (desc_fetch),
    .valid    (desc_valid),
    .state    (eng_state),
    .bad_desc (bad_desc)
  );

  dma_len_check #(
    .LEN_W (LEN_W), .CNT_W (CNT_W), .BLEN_W (BLEN_W), .SUM_W (SUM_W)
  ) u_len (
    .clk      (clk),
    .rst      (rst),
    .state    (eng_state),
    .done     (desc_done),
    .len      (desc_len),
    .last     (desc_end),
    .blk_cnt  (blk_cnt),
    .blk_len  (blk_len),
    .cnt_en   (blk_cnt_en),
    .mismatch (len_bad)
  );

  dma_err_regs #(.ADDR_W (ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .ev_bad_desc (bad_desc),
    .ev_len      (len_bad),
    .state       (eng_state),
    .addr        (desc_addr),
    .clr         (err_clr),
    .irq_en      (irq_en),
    .irq         (irq),
    .status      (status),
    .err_addr    (err_addr)
  );

  // R3: the invalid-descriptor event only arises in the fetch state
  assert_fetch_only_R3: assert property (@(posedge clk) disable iff (rst)
    bad_desc |-> (eng_state == ST_FETCH));
  // R7: reserved bits read zero
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
    status[7:3] == 5'b00000);
endmodule

// File: tb/dma_err_capture_tb.sv
module dma_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  eng_state;
  logic        desc_fetch, desc_valid, desc_done, desc_end;
  logic [31:0] desc_addr;
  logic [15:0] desc_len, blk_cnt;
  logic [11:0] blk_len;
  logic        blk_cnt_en, irq_en, err_clr;
  logic        irq;
  logic [7:0]  status;
  logic [31:0] err_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_err_capture u_dut (
    .clk(clk), .rst(rst), .eng_state(eng_state), .desc_fetch(desc_fetch),
    .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_done(desc_done),
    .desc_len(desc_len), .desc_end(desc_end), .blk_cnt(blk_cnt),
    .blk_len(blk_len), .blk_cnt_en(blk_cnt_en), .irq_en(irq_en),
    .err_clr(err_clr), .irq(irq), .status(status), .err_addr(err_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [7:0] st, input logic [31:0] ad,
                         input logic iq);
    chk({tag, " status"}, {24'h0, status}, {24'h0, st});
    chk({tag, " addr"}, err_addr, ad);
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, iq});
  endtask

  task automatic fetch(input logic [1:0] st, input logic [31:0] a, input logic v);
    eng_state = st; desc_fetch = 1'b1; desc_valid = v; desc_addr = a;
    @(negedge clk);
    desc_fetch = 1'b0; desc_valid = 1'b1;
  endtask

  task automatic complete(input logic [1:0] st, input logic [31:0] a,
                          input logic [15:0] l, input logic e);
    eng_state = st; desc_done = 1'b1; desc_addr = a; desc_len = l; desc_end = e;
    @(negedge clk);
    desc_done = 1'b0; desc_end = 1'b0;
  endtask

  task automatic clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk_all("R9 clear", 8'h00, 32'h0, 1'b0);
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 8'h00, 32'h0, 1'b0);
  endtask

  task automatic t_invalid_fetch();
    fetch(2'b01, 32'h100, 1'b1);
    chk_all("R3 valid fetch", 8'h00, 32'h0, 1'b0);
    fetch(2'b10, 32'h180, 1'b0);
    chk_all("R3 invalid in chadr", 8'h00, 32'h0, 1'b0);
    fetch(2'b11, 32'h190, 1'b0);
    chk_all("R3 invalid in xfer", 8'h00, 32'h0, 1'b0);
    fetch(2'b01, 32'h200, 1'b0);
    chk_all("R2 invalid fetch", 8'h01, 32'h200, 1'b1);
  endtask

  task automatic t_freeze();
    blk_len = 12'd512; blk_cnt = 16'd1; blk_cnt_en = 1'b1;
    complete(2'b11, 32'h900, 16'd100, 1'b1);
    chk_all("R8 later len error ignored", 8'h01, 32'h200, 1'b1);
    fetch(2'b01, 32'h300, 1'b0);
    chk_all("R8 later fetch error ignored", 8'h01, 32'h200, 1'b1);
    clear();
  endtask

  task automatic t_count_mismatch();
    blk_len = 12'd512; blk_cnt = 16'd3; blk_cnt_en = 1'b1;
    complete(2'b11, 32'h1000, 16'd1024, 1'b0);
    complete(2'b11, 32'h1008, 16'd512, 1'b1);
    chk_all("R4 matching chain", 8'h00, 32'h0, 1'b0);
    complete(2'b01, 32'h2000, 16'd7, 1'b1);
    chk_all("R4 completion outside xfer ignored", 8'h00, 32'h0, 1'b0);
    complete(2'b11, 32'h2ff8, 16'd1024, 1'b0);
    complete(2'b11, 32'h3000, 16'd1024, 1'b1);
    chk_all("R4 count mismatch", 8'h07, 32'h3000, 1'b1);
    clear();
  endtask

  task automatic t_not_multiple();
    blk_len = 12'd512; blk_cnt = 16'd3; blk_cnt_en = 1'b0;
    complete(2'b11, 32'h3ff8, 16'd1000, 1'b0);
    complete(2'b11, 32'h4000, 16'd24, 1'b1);
    chk_all("R5 multiple, count off, disabled", 8'h00, 32'h0, 1'b0);
    complete(2'b11, 32'h4100, 16'd512, 1'b0);
    complete(2'b11, 32'h4108, 16'd100, 1'b1);
    chk_all("R5 not multiple", 8'h07, 32'h4108, 1'b1);
    clear();
    blk_len = 12'd0;
    complete(2'b11, 32'h4200, 16'd64, 1'b1);
    chk_all("R5 zero block length", 8'h07, 32'h4200, 1'b1);
    clear();
  endtask

  task automatic t_len_zero();
    blk_len = 12'd2048; blk_cnt = 16'd32; blk_cnt_en = 1'b1;
    complete(2'b11, 32'h5000, 16'd0, 1'b1);
    chk_all("R6 zero length is 65536", 8'h00, 32'h0, 1'b0);
    blk_cnt = 16'd31;
    complete(2'b11, 32'h5100, 16'd0, 1'b1);
    chk_all("R6 zero length vs 31 blocks", 8'h07, 32'h5100, 1'b1);
    clear();
  endtask

  task automatic t_irq_gate();
    irq_en = 1'b0;
    fetch(2'b01, 32'h6000, 1'b0);
    chk_all("R10 irq masked", 8'h01, 32'h6000, 1'b0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq after enable", {31'h0, irq}, 32'h1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R10 irq after disable", {31'h0, irq}, 32'h0);
    irq_en = 1'b1;
    clear();
  endtask

  task automatic t_clear_wins();
    err_clr = 1'b1;
    fetch(2'b01, 32'h7000, 1'b0);
    err_clr = 1'b0;
    chk_all("R9 clear beats error", 8'h00, 32'h0, 1'b0);
    chk("R7 reserved bits", {24'h0, status & 8'hF8}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; eng_state = 2'b00; desc_fetch = 1'b0; desc_valid = 1'b1;
    desc_addr = '0; desc_done = 1'b0; desc_len = '0; desc_end = 1'b0;
    blk_cnt = '0; blk_len = 12'd512; blk_cnt_en = 1'b0; irq_en = 1'b1; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_invalid_fetch();
    t_freeze();
    t_count_mismatch();
    t_not_multiple();
    t_len_zero();
    t_irq_gate();
    t_clear_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule